// File: doc/BRIEF.md
# Bunch-Crossing Hit Window Filter and Lane Packetizer

This block sits behind a 16-channel timing front end. For each bunch crossing (BX) it receives one frame over a valid/ready handshake. The frame holds a 12-bit BX identifier, a presence mask with one bit per channel, a raw arrival time per channel counted in fine TDC bins, and a width value per channel. Each present hit is compared with a programmable acceptance window. Hits that fall outside the window are dropped as background. Channels with no surviving hit are left out entirely.

The survivors of one crossing form a single variable-length packet. The packet is a header word followed by one word per kept hit. Two payload formats exist. The normal format carries only the arrival time. The debug format adds the width value. The packet words go through an internal FIFO and are dealt round-robin over one to four output lanes, and each lane has its own valid/ready handshake.

Back-pressure works as follows. The input frame port is ready only while no packet is being assembled. A frame is taken on the clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the last word of that packet has entered the FIFO, which itself stalls while the FIFO is full. A lane word counts as taken on the edge where that lane's valid and ready are both high. Until then it is held.

Top module: `bx_hit_packetizer`

## Requirements
- R1: In fine mode (`cfg_coarse`=0) a present hit is kept if and only if `cfg_win_lo` <= t <= `cfg_win_hi` (both bounds inclusive), where t is the 9-bit raw arrival time.
- R2: In coarse mode (`cfg_coarse`=1) the effective time is t = raw >> 1. The window compare and the reported arrival field both use this effective time.
- R3: When `cfg_win_lo` > `cfg_win_hi`, every hit is discarded and the packet is header-only.
- R4: Every accepted frame produces exactly one header word. Bit 20 is 1, bits [16:12] hold the kept-hit count, bits [11:0] hold the BX ID and all other bits are 0. A crossing with no kept hits still yields this header, with a count of 0.
- R5: Hit words have bit 20 = 0 and follow the header in ascending channel order. A channel whose mask bit is 0, or whose hit was rejected, produces no word.
- R6: With `cfg_debug`=0 a hit word is {ch in [11:8], arrival in [7:0]} with all other bits 0. With `cfg_debug`=1 it is {ch in [19:16], arrival in [15:8], width in [7:0]}.
- R7: With N = `cfg_lanes`+1 active lanes, the words of a packet go to lanes 0,1,…,N-1,0,… in order. Every packet starts at lane 0, and lanes N and above never assert valid.
- R8: A lane word that is valid and not accepted keeps its valid bit and data unchanged in the next cycle.
- R9: After a frame is accepted, `in_ready` is low in the next cycle. It rises again only once the whole packet has been written into the FIFO.
- R10: The configuration inputs are sampled on the cycle a frame is accepted. Changing them while a packet is in flight does not alter that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_coarse | input | 1 | 1 = coarse bins (raw time halved) |
| cfg_debug | input | 1 | 1 = debug payload with width field |
| cfg_win_lo | input | 8 | Window lower bound, inclusive |
| cfg_win_hi | input | 8 | Window upper bound, inclusive |
| cfg_lanes | input | 2 | Active lane count minus one |
| in_valid | input | 1 | Frame valid |
| in_ready | output | 1 | Frame ready |
| in_bx | input | 12 | BX identifier |
| in_mask | input | 16 | Hit present per channel |
| in_toa | input | 144 | Raw arrival, 9 bits per channel, channel 0 in the low bits |
| in_tot | input | 128 | Width, 8 bits per channel, channel 0 in the low bits |
| lane_valid | output | 4 | Word valid per lane |
| lane_ready | input | 4 | Word ready per lane |
| lane_data | output | 84 | 21-bit word per lane, lane 0 in the low bits |

## Verification
The bench builds the block with its default parameters: 16 channels, 8-bit times, 4 lanes and an 8-entry FIFO. Because the FIFO is shallower than a full debug packet of 17 words, random lane back-pressure fills it and stalls packet assembly. This exercises the input back-pressure in R9. With four lanes, every active-lane count from 1 to 4 can be reached. Packets of 0 to 16 hits make the round-robin wrap at every lane position.

// File: rtl/bxp_pkg.sv
package bxp_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_HDR  = 2'd1,
    FR_HITS = 2'd2
  } fr_state_t;
endpackage

// File: rtl/bxp_window.sv
module bxp_window #(
  parameter int NCH = 16,
  parameter int TW  = 8,
  parameter int TIN = TW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coarse,
  input  logic [TW-1:0]      win_lo,
  input  logic [TW-1:0]      win_hi,
  input  logic [NCH-1:0]     mask,
  input  logic [NCH*TIN-1:0] toa_raw,
  output logic [NCH-1:0]     keep,
  output logic [NCH*TW-1:0]  toa_eff
);
  localparam int PADW = TIN - TW;

  logic [TIN-1:0] lo_ext, hi_ext;
  assign lo_ext = {{PADW{1'b0}}, win_lo};
  assign hi_ext = {{PADW{1'b0}}, win_hi};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [TIN-1:0] raw, t;
    assign raw = toa_raw[g*TIN +: TIN];
    assign t   = coarse ? (raw >> 1) : raw;
    assign keep[g] = mask[g] && (t >= lo_ext) && (t <= hi_ext);
    assign toa_eff[g*TW +: TW] = t[TW-1:0];
  end

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win_lo > win_hi) |-> (keep == '0)); // R3
endmodule

// File: rtl/bxp_framer.sv
module bxp_framer
  import bxp_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int TW     = 8,
  parameter int WW     = 8,
  parameter int BXW    = 12,
  parameter int LW     = 2,
  parameter int WORD_W = 21,
  parameter int E_W    = LW + 1 + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BXW-1:0]    in_bx,
  input  logic [NCH-1:0]    keep,
  input  logic [NCH*TW-1:0] toa_eff,
  input  logic [NCH*WW-1:0] in_tot,
  input  logic              cfg_debug,
  input  logic [LW-1:0]     cfg_lanes,
  output logic              push,
  output logic [E_W-1:0]    push_entry,
  input  logic              full
);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CNT_W = $clog2(NCH + 1);

  fr_state_t             st;
  logic [BXW-1:0]        bx_q;
  logic [NCH-1:0]        rem_q;
  logic [NCH*TW-1:0]     toa_q;
  logic [NCH*WW-1:0]     tot_q;
  logic                  dbg_q;
  logic [LW-1:0]         lanes_q;
  logic [CNT_W-1:0]      cnt_q, emitted_q;

  logic [CNT_W-1:0]      keep_cnt;
  logic [CH_W-1:0]       sel;
  logic [NCH-1:0]        rem_next;
  logic [WORD_W-1:0]     word;
  logic                  last;
  logic                  accept;

  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < NCH; i++) keep_cnt = keep_cnt + CNT_W'(keep[i]);
  end

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) if (rem_q[i]) sel = CH_W'(i);
  end

  always_comb begin
    rem_next = rem_q;
    rem_next[sel] = 1'b0;
  end

  assign in_ready = (st == FR_IDLE);
  assign accept   = in_valid && in_ready;
  assign push     = (st != FR_IDLE) && !full;

  always_comb begin
    word = '0;
    last = 1'b0;
    if (st == FR_HDR) begin
      word[WORD_W-1]     = 1'b1;
      word[BXW-1:0]      = bx_q;
      word[BXW +: CNT_W] = cnt_q;
      last               = (cnt_q == '0);
    end else begin
      if (dbg_q) begin
        word[WW-1:0]        = tot_q[sel*WW +: WW];
        word[WW +: TW]      = toa_q[sel*TW +: TW];
        word[WW+TW +: CH_W] = sel;
      end else begin
        word[TW-1:0]        = toa_q[sel*TW +: TW];
        word[TW +: CH_W]    = sel;
      end
      last = (rem_next == '0);
    end
  end

  assign push_entry = {lanes_q, last, word};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= FR_IDLE;
      bx_q      <= '0;
      rem_q     <= '0;
      toa_q     <= '0;
      tot_q     <= '0;
      dbg_q     <= 1'b0;
      lanes_q   <= '0;
      cnt_q     <= '0;
      emitted_q <= '0;
    end else begin
      case (st)
        FR_IDLE: if (accept) begin
          bx_q      <= in_bx;
          rem_q     <= keep;
          toa_q     <= toa_eff;
          tot_q     <= in_tot;
          dbg_q     <= cfg_debug;
          lanes_q   <= cfg_lanes;
          cnt_q     <= keep_cnt;
          emitted_q <= '0;
          st        <= FR_HDR;
        end
        FR_HDR: if (push) st <= last ? FR_IDLE : FR_HITS;
        FR_HITS: if (push) begin
          rem_q     <= rem_next;
          emitted_q <= emitted_q + 1'b1;
          if (last) st <= FR_IDLE;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R9
  AST_HIT_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_HITS && push && last) |-> (emitted_q + 1'b1 == cnt_q)); // R4
endmodule

// File: rtl/bxp_fifo.sv
module bxp_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
endmodule

// File: rtl/bxp_lane_dist.sv
module bxp_lane_dist #(
  parameter int NLANE  = 4,
  parameter int LW     = 2,
  parameter int WORD_W = 21,
  parameter int E_W    = LW + 1 + WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [E_W-1:0]          head,
  input  logic                    empty,
  output logic                    pop,
  output logic [NLANE-1:0]        lane_valid,
  input  logic [NLANE-1:0]        lane_ready,
  output logic [NLANE*WORD_W-1:0] lane_data
);
  logic [LW-1:0]     ptr;
  logic [LW-1:0]     h_lanes;
  logic              h_last;
  logic [WORD_W-1:0] h_word;
  logic [NLANE-1:0]  active;

  assign {h_lanes, h_last, h_word} = head;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_valid[g] = !empty && (ptr == LW'(g));
    assign lane_data[g*WORD_W +: WORD_W] = h_word;
    assign active[g] = (LW'(g) <= h_lanes);
  end

  assign pop = !empty && lane_ready[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (pop) ptr <= (h_last || ptr == h_lanes) ? '0 : ptr + 1'b1;
  end

  AST_LANE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid & ~active) == '0); // R7
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_valid)); // R7
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lane_valid & ~lane_ready)) |=> ($stable(lane_valid) && $stable(h_word))); // R8
endmodule

// File: rtl/bx_hit_packetizer.sv
module bx_hit_packetizer #(
  parameter int NCH   = 16,
  parameter int TW    = 8,
  parameter int WW    = 8,
  parameter int BXW   = 12,
  parameter int NLANE = 4,
  parameter int DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_coarse,
  input  logic                    cfg_debug,
  input  logic [TW-1:0]           cfg_win_lo,
  input  logic [TW-1:0]           cfg_win_hi,
  input  logic [LW-1:0]           cfg_lanes,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BXW-1:0]          in_bx,
  input  logic [NCH-1:0]          in_mask,
  input  logic [NCH*TIN-1:0]      in_toa,
  input  logic [NCH*WW-1:0]       in_tot,
  output logic [NLANE-1:0]        lane_valid,
  input  logic [NLANE-1:0]        lane_ready,
  output logic [NLANE*WORD_W-1:0] lane_data
);
  localparam int LW     = (NLANE > 1) ? $clog2(NLANE) : 1;
  localparam int TIN    = TW + 1;
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CNT_W  = $clog2(NCH + 1);
  localparam int HIT_W  = 1 + CH_W + TW + WW;
  localparam int HDR_W  = 1 + CNT_W + BXW;
  localparam int WORD_W = (HIT_W > HDR_W) ? HIT_W : HDR_W;
  localparam int E_W    = LW + 1 + WORD_W;

  logic [NCH-1:0]    keep;
  logic [NCH*TW-1:0] toa_eff;
  logic              push, pop, full, empty;
  logic [E_W-1:0]    push_entry, head;

  bxp_window #(.NCH(NCH), .TW(TW), .TIN(TIN)) u_win (
    .clk(clk), .rst_n(rst_n), .coarse(cfg_coarse),
    .win_lo(cfg_win_lo), .win_hi(cfg_win_hi),
    .mask(in_mask), .toa_raw(in_toa), .keep(keep), .toa_eff(toa_eff)
  );

  bxp_framer #(.NCH(NCH), .TW(TW), .WW(WW), .BXW(BXW), .LW(LW),
               .WORD_W(WORD_W), .E_W(E_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bx(in_bx), .keep(keep), .toa_eff(toa_eff), .in_tot(in_tot),
    .cfg_debug(cfg_debug), .cfg_lanes(cfg_lanes),
    .push(push), .push_entry(push_entry), .full(full)
  );

  bxp_fifo #(.W(E_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_entry),
    .pop(pop), .dout(head), .full(full), .empty(empty)
  );

  bxp_lane_dist #(.NLANE(NLANE), .LW(LW), .WORD_W(WORD_W), .E_W(E_W)) u_dist (
    .clk(clk), .rst_n(rst_n), .head(head), .empty(empty), .pop(pop),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_data(lane_data)
  );
endmodule

// File: tb/sim_bx_hit_packetizer.sv
module sim_bx_hit_packetizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_coarse = 0, cfg_debug = 0;
  logic [7:0]  cfg_win_lo = 0, cfg_win_hi = 8'hFF;
  logic [1:0]  cfg_lanes = 0;
  logic        in_valid = 0, in_ready;
  logic [11:0] in_bx = 0;
  logic [15:0] in_mask = 0;
  logic [143:0] in_toa = 0;
  logic [127:0] in_tot = 0;
  logic [3:0]  lane_valid, lane_ready = 0;
  logic [83:0] lane_data;

  bx_hit_packetizer u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [20:0] exp_w[$];
  logic        exp_last[$];
  int          exp_nl[$];
  int          exp_lane = 0;
  logic        started = 0;
  logic [8:0]  ht[16];
  logic [7:0]  hw[16];
  logic [15:0] hm;
  logic [3:0]  stall_prev = 0;
  logic [20:0] data_prev[4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic model();
    int cnt = 0;
    logic [8:0] t;
    logic keep[16];
    logic [20:0] w;
    for (int c = 0; c < 16; c++) begin
      t = cfg_coarse ? (ht[c] >> 1) : ht[c];
      keep[c] = hm[c] && (t >= {1'b0, cfg_win_lo}) && (t <= {1'b0, cfg_win_hi});
      if (keep[c]) cnt++;
    end
    w = 0; w[20] = 1; w[16:12] = 5'(cnt); w[11:0] = in_bx;
    exp_w.push_back(w); exp_last.push_back(cnt == 0); exp_nl.push_back(cfg_lanes + 1);
    for (int c = 0; c < 16; c++) if (keep[c]) begin
      t = cfg_coarse ? (ht[c] >> 1) : ht[c];
      w = 0;
      if (cfg_debug) begin w[19:16] = 4'(c); w[15:8] = t[7:0]; w[7:0] = hw[c]; end
      else begin w[11:8] = 4'(c); w[7:0] = t[7:0]; end
      cnt--;
      exp_w.push_back(w); exp_last.push_back(cnt == 0); exp_nl.push_back(cfg_lanes + 1);
    end
  endtask

  task automatic clear_hits();
    hm = 0;
    for (int c = 0; c < 16; c++) begin ht[c] = 0; hw[c] = 0; end
  endtask

  task automatic send(input logic [11:0] bx);
    @(negedge clk);
    in_bx = bx; in_mask = hm;
    for (int c = 0; c < 16; c++) begin in_toa[c*9 +: 9] = ht[c]; in_tot[c*8 +: 8] = hw[c]; end
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    model();
    @(negedge clk);
    chk(!in_ready, "R9 busy after accept", 32'(in_ready), 0);
    in_valid = 0;
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int l = 0; l < 4; l++) begin
        if (stall_prev[l])
          chk(lane_valid[l] && lane_data[l*21 +: 21] == data_prev[l], "R8 hold",
              32'(lane_data[l*21 +: 21]), 32'(data_prev[l]));
        lane_ready[l] = ($urandom_range(0, 3) != 0);
      end
      for (int l = 0; l < 4; l++) begin
        if (lane_valid[l] && lane_ready[l]) begin
          if (exp_w.size() == 0) chk(0, "R4 unexpected word", 32'(lane_data[l*21 +: 21]), 0);
          else begin
            chk(l == exp_lane, "R7 lane", l, exp_lane);
            chk(lane_data[l*21 +: 21] == exp_w[0], "R4/R5/R6 word",
                32'(lane_data[l*21 +: 21]), 32'(exp_w[0]));
            if (exp_last[0]) exp_lane = 0;
            else exp_lane = (exp_lane + 1) % exp_nl[0];
            void'(exp_w.pop_front()); void'(exp_last.pop_front()); void'(exp_nl.pop_front());
          end
        end
        stall_prev[l] = lane_valid[l] && !lane_ready[l];
        data_prev[l] = lane_data[l*21 +: 21];
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(in_ready == 1, "R9 reset ready", 32'(in_ready), 1);
    chk(lane_valid == 0, "R7 reset lanes idle", 32'(lane_valid), 0);
    started = 1;

    // R1: fine mode, boundaries inclusive, mask gating (R5)
    cfg_win_lo = 10; cfg_win_hi = 100;
    clear_hits();
    hm[0] = 1; ht[0] = 10;
    hm[1] = 1; ht[1] = 100;
    hm[2] = 1; ht[2] = 9;
    hm[3] = 1; ht[3] = 101;
    hm[7] = 1; ht[7] = 50;
    ht[8] = 50;
    hm[15] = 1; ht[15] = 300;
    send(12'h001);

    // R2: coarse mode halves the raw time
    cfg_coarse = 1;
    clear_hits();
    hm[4] = 1; ht[4] = 201;
    hm[5] = 1; ht[5] = 202;
    hm[6] = 1; ht[6] = 19;
    hm[9] = 1; ht[9] = 20;
    send(12'h002);
    cfg_coarse = 0;

    // R3: empty window
    cfg_win_lo = 60; cfg_win_hi = 59;
    clear_hits();
    for (int c = 0; c < 16; c++) begin hm[c] = 1; ht[c] = 9'(59 + c % 2); end
    send(12'h003);

    // R4: no hits at all
    cfg_win_lo = 0; cfg_win_hi = 255;
    clear_hits();
    send(12'hFFF);

    // R6 + R7: debug mode, all channels, four lanes
    cfg_debug = 1; cfg_lanes = 3;
    clear_hits();
    for (int c = 0; c < 16; c++) begin hm[c] = 1; ht[c] = 9'(c * 13); hw[c] = 8'(200 - c); end
    send(12'h0A5);

    // R7: two and three lanes, odd lengths
    for (int n = 1; n < 3; n++) begin
      cfg_lanes = 2'(n);
      clear_hits();
      for (int c = 0; c < 16; c += 3) begin hm[c] = 1; ht[c] = 9'(c + 1); hw[c] = 8'(c); end
      send(12'(16 + n));
    end

    // R10: config changed right after acceptance
    cfg_debug = 1; cfg_lanes = 2; cfg_win_lo = 0; cfg_win_hi = 255;
    clear_hits();
    for (int c = 0; c < 16; c += 2) begin hm[c] = 1; ht[c] = 9'(c * 5); hw[c] = 8'hA0 + 8'(c); end
    send(12'h200);
    cfg_debug = 0; cfg_lanes = 0; cfg_win_lo = 20; cfg_win_hi = 40;
    send(12'h201);

    // back-to-back random frames
    for (int k = 0; k < 30; k++) begin
      cfg_debug = 1'($urandom_range(0, 1));
      cfg_coarse = 1'($urandom_range(0, 1));
      cfg_lanes = 2'($urandom_range(0, 3));
      cfg_win_lo = 8'($urandom_range(0, 120));
      cfg_win_hi = 8'($urandom_range(60, 255));
      clear_hits();
      for (int c = 0; c < 16; c++) begin
        hm[c] = 1'($urandom_range(0, 1));
        ht[c] = 9'($urandom_range(0, 511));
        hw[c] = 8'($urandom_range(0, 255));
      end
      send(12'(k * 37));
    end

    while (exp_w.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(lane_valid == 0, "R4 no extra words", 32'(lane_valid), 0);
    chk(in_ready == 1, "R9 ready when drained", 32'(in_ready), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule